// File: doc/BRIEF.md
# APB Transfer Master

This block turns a simple command stream into single transfers on an APB bus. A requester offers an address, a direction bit and write data on a valid/ready handshake. The block then runs the bus through its idle, setup and access phases. It waits in the access phase for as long as the target keeps its ready input low. When the transfer completes it hands back the read data and the error indication on a one-cycle response strobe.

Back-pressure on the command side comes only from the bus. `cmd_ready` is high when the block is idle, and again in the cycle where an access completes. A requester that keeps `cmd_valid` high with a new command during that completing cycle has the command taken at once. The bus then goes straight from access into the next setup phase, with no idle cycle between them. A command must stay unchanged while `cmd_valid` is high and `cmd_ready` is low.

The response side has no back-pressure. `rsp_valid` is a single-cycle strobe, and the requester must take it in the cycle it appears. All logic runs on the rising edge of `clk`. `rst_n` is an active-low asynchronous reset.

Top module: `apb_xfer_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it: `bus_sel`=0, `bus_en`=0, `rsp_valid`=0 and `cmd_ready`=1.
- R2: A command accepted from idle (`cmd_valid` and `cmd_ready` both high at a rising edge) gives a setup phase in the next cycle. In setup, `bus_sel`=1 and `bus_en`=0, and `bus_addr`, `bus_write` and `bus_wdata` carry the command. `bus_write`=1 means write and 0 means read.
- R3: Setup lasts exactly one cycle. The cycle after it is always an access phase, with `bus_sel`=1 and `bus_en`=1.
- R4: From setup until the access completes, `bus_addr`, `bus_write`, `bus_wdata` and `bus_sel` hold their values. The access phase lasts for any number of cycles in which `bus_ready` is low.
- R5: `cmd_ready` is high only in idle, or in access while `bus_ready` is high. A command offered at any other time is not taken.
- R6: If a command is accepted in the completing access cycle, the next cycle is the setup phase of that command, with no idle cycle between them.
- R7: If no command is pending when an access completes, the next cycle is idle (`bus_sel`=0, `bus_en`=0).
- R8: `rsp_valid` is high for exactly the one cycle that follows each completing access cycle. `rsp_err` then equals `bus_err` as sampled on the completing cycle. `rsp_rdata` equals `bus_rdata` sampled on that cycle for a read, and is zero for a write.
- R9: `bus_rdata` and `bus_err` seen during setup or during access wait cycles have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The command is taken at this edge |
| cmd_write | input | 1 | Command direction, 1 = write |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data, zero for writes |
| rsp_err | output | 1 | Transfer failed |
| bus_sel | output | 1 | Target select |
| bus_en | output | 1 | Access-phase enable |
| bus_write | output | 1 | Bus direction, 1 = write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Read data from the target |
| bus_ready | input | 1 | Target completes the access |
| bus_err | input | 1 | Target reports an error |

## Verification
The hardest case to reach is a chained transfer that follows a stretched access. To produce it, a new command must already be waiting while the target holds the bus in wait states, and it must be taken only in the one cycle where ready rises. The bench's target model draws 0 to 3 wait states per transfer. It drives deliberately wrong read data and a raised error flag during the wait cycles. The requester keeps a command pending most of the time, so chains follow both short and long accesses. A behavioural model checks every cycle that the pending command is taken in the completing cycle and not before.

// File: rtl/apb_xfer_pkg.sv
package apb_xfer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;
endpackage

// File: rtl/apb_phase_fsm.sv
module apb_phase_fsm
  import apb_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic bus_ready,
  output logic cmd_ready,
  output logic load,
  output logic done,
  output logic sel,
  output logic en
);

  phase_e phase_q, phase_d;

  assign done      = (phase_q == PH_ACCESS) && bus_ready;
  assign cmd_ready = (phase_q == PH_IDLE) || done;
  assign load      = cmd_valid && cmd_ready;
  assign sel       = (phase_q != PH_IDLE);
  assign en        = (phase_q == PH_ACCESS);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (cmd_valid) phase_d = PH_SETUP;
      PH_SETUP:  phase_d = PH_ACCESS;
      PH_ACCESS: if (bus_ready) phase_d = cmd_valid ? PH_SETUP : PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // R3: setup is one cycle and always advances to access
  p_setup_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP) |=> (phase_q == PH_ACCESS));

  // R4: a wait state keeps the access phase
  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACCESS && !bus_ready) |=> (phase_q == PH_ACCESS));

  // R6: a command taken on completion goes straight to setup
  p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_valid) |=> (phase_q == PH_SETUP));

  // R7: completion with nothing pending returns to idle
  p_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_valid) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/apb_cmd_hold.sv
module apb_cmd_hold #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              hold_write,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_write <= 1'b0;
      hold_addr  <= '0;
      hold_wdata <= '0;
    end else if (load) begin
      hold_write <= cmd_write;
      hold_addr  <= cmd_addr;
      hold_wdata <= cmd_wdata;
    end
  end
endmodule

// File: rtl/apb_rsp_capture.sv
module apb_rsp_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              is_write,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (done) begin
        rsp_rdata <= is_write ? '0 : bus_rdata;
        rsp_err   <= bus_err;
      end
    end
  end
endmodule

// File: rtl/apb_xfer_master.sv
module apb_xfer_master #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_sel,
  output logic              bus_en,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err
);

  logic load, done;

  apb_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .bus_ready(bus_ready),
    .cmd_ready(cmd_ready), .load(load), .done(done), .sel(bus_sel), .en(bus_en)
  );

  apb_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .hold_write(bus_write),
    .hold_addr(bus_addr), .hold_wdata(bus_wdata)
  );

  apb_rsp_capture #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .done(done), .is_write(bus_write),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  // R2: enable never without select
  p_en_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> bus_sel);

  // R4: setup and wait cycles keep the bus fields stable into the next cycle
  p_stable_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !(bus_en && bus_ready)) |=>
      (bus_sel && bus_en && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

  // R5: ready while selected only on the completing cycle
  p_ready_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && bus_sel) |-> (bus_en && bus_ready));

  // R8: response strobe follows completion, and only completion
  p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_ready) |=> rsp_valid);
  p_rsp_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_ready) |=> !rsp_valid);
endmodule

// File: tb/apb_xfer_master_tb.sv
module apb_xfer_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int RUN_CYCLES = 3000;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic bus_sel, bus_en, bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_ready = 1'b0, bus_err = 1'b0;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit done_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_xfer_master #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  function automatic logic [DW-1:0] tgt_data(input logic [AW-1:0] a);
    return ({20'h0, a} * 32'h0001_0003) ^ 32'h5A5A_1234;
  endfunction
  function automatic logic tgt_err(input logic [AW-1:0] a);
    return a[3:0] == 4'hF;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 setup, 2 access
  int m_phase;
  logic m_wr, m_rv, m_err;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_rv <= 0; m_err <= 0; m_rd <= '0;
      m_wr <= 0; m_addr <= '0; m_wd <= '0;
    end else begin
      m_rv <= 0;
      if (m_phase == 0) begin
        if (cmd_valid) begin
          m_phase <= 1; m_wr <= cmd_write; m_addr <= cmd_addr; m_wd <= cmd_wdata;
        end
      end else if (m_phase == 1) begin
        m_phase <= 2;
      end else if (bus_ready) begin
        m_rv <= 1;
        m_rd <= m_wr ? '0 : tgt_data(m_addr);
        m_err <= tgt_err(m_addr);
        if (cmd_valid) begin
          m_phase <= 1; m_wr <= cmd_write; m_addr <= cmd_addr; m_wd <= cmd_wdata;
        end else m_phase <= 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done_run) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic new_cmd();
    cmd_write = $urandom_range(0, 1);
    cmd_addr  = AW'($urandom);
    cmd_wdata = $urandom;
  endtask

  initial begin
    int waits = 0;
    bit prev_acc = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 sel", bus_sel, 0); check("R1 en", bus_en, 0);
    check("R1 rsp_valid", rsp_valid, 0); check("R1 cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sel after reset", bus_sel, 0); check("R1 rsp after reset", rsp_valid, 0);
    for (int c = 0; c < RUN_CYCLES; c++) begin
      if (c > 0) @(negedge clk);
      // registered outputs against the model
      check("R2/R3/R6/R7 sel", bus_sel, m_phase != 0);
      check("R3/R6/R7 en", bus_en, m_phase == 2);
      if (m_phase != 0) begin
        check("R2/R4 addr", bus_addr, m_addr);
        check("R2/R4 write", bus_write, m_wr);
        check("R2/R4 wdata", bus_wdata, m_wd);
      end
      check("R8 rsp_valid", rsp_valid, m_rv);
      if (m_rv) begin
        check("R8/R9 rsp_rdata", rsp_rdata, m_rd);
        check("R8/R9 rsp_err", rsp_err, m_err);
      end
      // requester: new command after acceptance, held otherwise
      if (prev_acc || !cmd_valid) begin
        cmd_valid = (c < RUN_CYCLES - 20) && ($urandom_range(0, 3) != 0);
        if (cmd_valid) new_cmd();
      end
      // target model with 0..3 wait states and junk during waits
      if (bus_sel && !bus_en) waits = $urandom_range(0, 3);
      if (bus_sel && bus_en && waits == 0) begin
        bus_ready = 1; bus_rdata = tgt_data(bus_addr); bus_err = tgt_err(bus_addr);
      end else begin
        if (bus_sel && bus_en) waits--;
        bus_ready = 0; bus_rdata = 32'hDEAD_BEEF; bus_err = 1;
      end
      #1;
      // R5: ready only in idle or on the completing access cycle
      check("R5 cmd_ready", cmd_ready, (m_phase == 0) || (m_phase == 2 && bus_ready));
      prev_acc = cmd_valid && cmd_ready;
    end
    done_run = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule